// File: doc/BRIEF.md
# Bus Owner and Event Notification Register Block

This block sits behind a quadlet-addressed register bus. It keeps a 64-bit owner address, a stream run flag, a clock selection word and a read-only event word. The owner address has a 16-bit node identifier in its upper bits and a 48-bit offset inside that node in its lower bits. Host software claims or releases the block by changing that address. Plain writes cannot change it. The only way to change it is an atomic compare-and-swap request. That request always returns the value the owner held before.

Event pulses from the surrounding logic arrive at the block, and so does a completion event that the block makes itself after each clock selection write. Each non-empty set of events replaces the stored event word. When an owner is set, the block also raises an outgoing write request that carries the new word and the owner address. It holds that request until the transaction layer acknowledges it. A bus reset input drops ownership, stops the streams and withdraws any pending request.

Top module: `oen_regs_top`

## Requirements
- R1: After reset, register index 0 (owner bits 63:32) reads 0xFFFF0000 and index 1 (owner bits 31:0) reads 0, so the owner holds the no-owner value 0xFFFF_0000_0000_0000. Index 2 (event word) reads 0 and index 4 (run flag) reads 0. `ntf_req` and `stream_en` are low, and the clock selection holds source 0x0C with rate code 0x02.
- R2: A bus write to register index 0 or 1 leaves the owner value unchanged.
- R3: A compare-and-swap request returns the previous owner on `cas_old`, with `cas_done` high, one cycle after it is presented. It replaces the owner with `cas_new` only when the previous owner equals `cas_cmp`.
- R4: In a cycle where any event bit is set, the event word (index 2) becomes exactly that set of bits, and bits from earlier events are dropped. The bit meanings are: bit 0 receive configuration changed, bit 1 transmit configuration changed, bit 4 current source lock changed, bit 5 clock selection accepted, bit 6 lock of some source changed.
- R5: When an event set is latched while the owner is not the no-owner value, `ntf_req` rises in the next cycle. It carries the event word on `ntf_data` and the owner on `ntf_addr`. When the owner is the no-owner value, no request is raised.
- R6: `ntf_req` stays high until a cycle with `ntf_ack` high. If a new event set arrives while a request is pending, `ntf_data` takes the new word and the request stays high.
- R7: A `bus_rst` pulse sets the owner to the no-owner value, clears the run flag and drops a pending request. It wins over a matching compare-and-swap presented in the same cycle.
- R8: A write to index 3 stores the source code from bits 7:0 and the rate code from bits 15:8 (0x0 to 0x6 are 32 to 192 kHz, 0xA is no rate). These appear on `clk_src` and `clk_rate` and read back from index 3. One cycle after the register updates, event bit 5 is latched.
- R9: A write of any non-zero value to index 4 sets `stream_en`, and a write of zero clears it. Index 4 reads back 1 or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse |
| req_valid | input | 1 | Register access strobe |
| req_wr | input | 1 | Access is a write |
| req_idx | input | IDX_W | Quadlet index of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| cas_valid | input | 1 | Compare-and-swap request |
| cas_cmp | input | 64 | Compare operand |
| cas_new | input | 64 | Swap operand |
| cas_old | output | 64 | Owner value before the request |
| cas_done | output | 1 | `cas_old` is valid |
| evt_in | input | NTF_W | Event pulses from surrounding logic |
| clk_src | output | SRC_W | Selected clock source |
| clk_rate | output | RATE_W | Selected rate code |
| stream_en | output | 1 | Streams run |
| ntf_req | output | 1 | Outgoing notification write pending |
| ntf_ack | input | 1 | Notification write taken |
| ntf_addr | output | 64 | Destination of the notification |
| ntf_data | output | NTF_W | Notification word |

## Verification
Several rules are checked by assertions on every cycle. The owner changes only after a matching swap or a bus reset. A bus reset leaves the owner empty and the streams stopped. A pending request is never dropped without an acknowledge or a bus reset. A request only rises while an owner is set. Each event set replaces the event word. A clock selection write is followed two cycles later by the accepted bit. The bench scenarios cover the rest. They show that a plain write to the owner quadlets is ignored, that a failing swap returns the old value and leaves the owner alone, and that a new event replaces the data of a pending request. They also show the read-back values of every register and that a bus reset wins over a matching swap in the same cycle.

// File: rtl/oen_pkg.sv
package oen_pkg;
   localparam int          OWN_W    = 64;
   localparam int          Q_W      = 32;
   localparam logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000;

   // event bit positions
   localparam int EVT_RX_CFG   = 0;
   localparam int EVT_TX_CFG   = 1;
   localparam int EVT_LOCK     = 4;
   localparam int EVT_CLK_ACC  = 5;
   localparam int EVT_EXT_LOCK = 6;

   // quadlet indexes
   localparam int IDX_OWN_HI = 0;
   localparam int IDX_OWN_LO = 1;
   localparam int IDX_NTF    = 2;
   localparam int IDX_CLK    = 3;
   localparam int IDX_RUN    = 4;
endpackage

// File: rtl/oen_owner_cas.sv
module oen_owner_cas
   import oen_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             cas_valid,
   input  logic [OWN_W-1:0] cas_cmp,
   input  logic [OWN_W-1:0] cas_new,
   output logic [OWN_W-1:0] cas_old,
   output logic             cas_done,
   output logic [OWN_W-1:0] owner
);
   logic hit;
   assign hit = cas_valid && (owner == cas_cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner    <= NO_OWNER;
         cas_old  <= '0;
         cas_done <= 1'b0;
      end else begin
         cas_done <= cas_valid;
         if (cas_valid) cas_old <= owner;
         if (bus_rst)  owner <= NO_OWNER;
         else if (hit) owner <= cas_new;
      end
   end

   // R2, R3
   owner_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(owner) |-> ($past(bus_rst) || $past(cas_valid && (cas_cmp == owner))));

   // R7
   bus_rst_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (owner == NO_OWNER));

   // R3
   cas_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cas_valid |=> (cas_done && (cas_old == $past(owner))));
endmodule

// File: rtl/oen_cfg_regs.sv
module oen_cfg_regs #(
   parameter int          SRC_W    = 8,
   parameter int          RATE_W   = 8,
   parameter logic [15:0] CSEL_DEF = 16'h020C,
   localparam int         CSEL_W   = SRC_W + RATE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              wr_clk,
   input  logic              wr_run,
   input  logic [31:0]       wdata,
   output logic [CSEL_W-1:0] clk_sel,
   output logic              stream_en,
   output logic              clk_acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sel   <= CSEL_W'(CSEL_DEF);
         stream_en <= 1'b0;
         clk_acc   <= 1'b0;
      end else begin
         clk_acc <= wr_clk;
         if (wr_clk) clk_sel <= wdata[CSEL_W-1:0];
         if (bus_rst)     stream_en <= 1'b0;
         else if (wr_run) stream_en <= |wdata;
      end
   end

   // R7
   run_bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !stream_en);

   // R9
   run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_run && !bus_rst) |=> (stream_en == ($past(wdata) != 32'd0)));
endmodule

// File: rtl/oen_notify.sv
module oen_notify
   import oen_pkg::*;
#(
   parameter int NTF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic [NTF_W-1:0] evt,
   input  logic [OWN_W-1:0] owner,
   input  logic             ntf_ack,
   output logic [NTF_W-1:0] ntf_word,
   output logic             ntf_req,
   output logic [OWN_W-1:0] ntf_addr
);
   logic any_evt, owned;
   assign any_evt = |evt;
   assign owned   = (owner != NO_OWNER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ntf_word <= '0;
         ntf_req  <= 1'b0;
         ntf_addr <= NO_OWNER;
      end else begin
         if (any_evt) ntf_word <= evt;
         if (bus_rst) ntf_req <= 1'b0;
         else if (any_evt && owned) begin
            ntf_req  <= 1'b1;
            ntf_addr <= owner;
         end else if (ntf_ack) ntf_req <= 1'b0;
      end
   end

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_req && !ntf_ack && !bus_rst) |=> ntf_req);

   // R5
   req_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ntf_req) |-> ($past(owner) != NO_OWNER));

   // R4
   evt_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> (ntf_word == $past(evt)));
endmodule

// File: rtl/oen_regs_top.sv
module oen_regs_top
   import oen_pkg::*;
#(
   parameter int IDX_W   = 3,
   parameter int NTF_W   = 32,
   parameter int SRC_W   = 8,
   parameter int RATE_W  = 8,
   parameter bit RD_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              req_valid,
   input  logic              req_wr,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rd_data,
   input  logic              cas_valid,
   input  logic [63:0]       cas_cmp,
   input  logic [63:0]       cas_new,
   output logic [63:0]       cas_old,
   output logic              cas_done,
   input  logic [NTF_W-1:0]  evt_in,
   output logic [SRC_W-1:0]  clk_src,
   output logic [RATE_W-1:0] clk_rate,
   output logic              stream_en,
   output logic              ntf_req,
   input  logic              ntf_ack,
   output logic [63:0]       ntf_addr,
   output logic [NTF_W-1:0]  ntf_data
);
   localparam int CSEL_W = SRC_W + RATE_W;

   if (NTF_W <= EVT_EXT_LOCK || NTF_W > Q_W) begin : g_bad_ntf
      $error("NTF_W must hold the event bits and fit one quadlet");
   end
   if (IDX_W < 3) begin : g_bad_idx
      $error("IDX_W too narrow for the register map");
   end
   if (CSEL_W > Q_W) begin : g_bad_csel
      $error("clock selection wider than a quadlet");
   end

   logic [OWN_W-1:0]  owner;
   logic [CSEL_W-1:0] clk_sel;
   logic              clk_acc, wr_clk, wr_run;
   logic [NTF_W-1:0]  evt_all, ntf_word;
   logic [31:0]       rd_c;

   assign wr_clk = req_valid && req_wr && (req_idx == IDX_W'(IDX_CLK));
   assign wr_run = req_valid && req_wr && (req_idx == IDX_W'(IDX_RUN));

   always_comb begin
      evt_all              = evt_in;
      evt_all[EVT_CLK_ACC] = evt_in[EVT_CLK_ACC] | clk_acc;
   end

   oen_owner_cas i_own (
      .clk, .rst_n, .bus_rst, .cas_valid, .cas_cmp, .cas_new,
      .cas_old, .cas_done, .owner
   );

   oen_cfg_regs #(.SRC_W(SRC_W), .RATE_W(RATE_W)) i_cfg (
      .clk, .rst_n, .bus_rst, .wr_clk, .wr_run, .wdata(req_wdata),
      .clk_sel, .stream_en, .clk_acc
   );

   oen_notify #(.NTF_W(NTF_W)) i_ntf (
      .clk, .rst_n, .bus_rst, .evt(evt_all), .owner, .ntf_ack,
      .ntf_word, .ntf_req, .ntf_addr
   );

   assign ntf_data = ntf_word;
   assign clk_src  = clk_sel[SRC_W-1:0];
   assign clk_rate = clk_sel[CSEL_W-1:SRC_W];

   always_comb begin
      rd_c = '0;
      case (req_idx)
         IDX_W'(IDX_OWN_HI): rd_c = owner[63:32];
         IDX_W'(IDX_OWN_LO): rd_c = owner[31:0];
         IDX_W'(IDX_NTF):    rd_c = Q_W'(ntf_word);
         IDX_W'(IDX_CLK):    rd_c = Q_W'(clk_sel);
         IDX_W'(IDX_RUN):    rd_c = Q_W'(stream_en);
         default:            rd_c = '0;
      endcase
   end

   if (RD_PIPE) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         rd_data <= '0;
         else if (req_valid) rd_data <= rd_c;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_c;
   end

   // R8
   clk_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clk |=> ##1 ntf_word[EVT_CLK_ACC]);
endmodule

// File: tb/test_oen_regs_top.sv
module test_oen_regs_top;
   localparam int CLK_P = 10;
   localparam logic [2:0] OP_WR = 0, OP_RD = 1, OP_CAS = 2, OP_EVT = 3,
                          OP_BR = 4, OP_ACK = 5, OP_ADR = 6;
   localparam logic [63:0] NOWN = 64'hFFFF_0000_0000_0000;
   localparam logic [63:0] OWN1 = 64'hFFC2_0000_1000_0000;
   localparam logic [63:0] OWN2 = 64'h0001_0000_0000_0100;
   localparam int NV = 23;
   localparam int VW = 198;

   // {op, idx, a, b, expected}
   localparam logic [VW-1:0] VEC [0:NV-1] = '{
      {OP_RD,  3'd0, 64'h0, 64'h0, 64'hFFFF_0000},            // R1
      {OP_RD,  3'd2, 64'h0, 64'h0, 64'h0},                    // R1
      {OP_WR,  3'd0, 64'h1234, 64'h0, 64'h0},                 // R2
      {OP_WR,  3'd1, 64'h5678, 64'h0, 64'h0},                 // R2
      {OP_RD,  3'd0, 64'h0, 64'h0, 64'hFFFF_0000},            // R2
      {OP_RD,  3'd1, 64'h0, 64'h0, 64'h0},                    // R2
      {OP_EVT, 3'd0, 64'h1, 64'h0, 64'h0000_0000_0000_0001},  // R5 no owner
      {OP_CAS, 3'd0, 64'h1111, OWN1, NOWN},                   // R3 miss
      {OP_RD,  3'd0, 64'h0, 64'h0, 64'hFFFF_0000},            // R3
      {OP_CAS, 3'd0, NOWN, OWN1, NOWN},                       // R3 hit
      {OP_RD,  3'd1, 64'h0, 64'h0, 64'h1000_0000},            // R3
      {OP_EVT, 3'd0, 64'h12, 64'h0, 64'h0000_0001_0000_0012}, // R4 R5
      {OP_ADR, 3'd0, 64'h0, 64'h0, OWN1},                     // R5
      {OP_ACK, 3'd0, 64'h0, 64'h0, 64'h0},                    // R6
      {OP_WR,  3'd3, 64'h0407, 64'h0, 64'h0},                 // R8
      {OP_RD,  3'd3, 64'h0, 64'h0, 64'h0407},                 // R8
      {OP_RD,  3'd2, 64'h0, 64'h0, 64'h20},                   // R8
      {OP_ACK, 3'd0, 64'h0, 64'h0, 64'h0},                    // R6
      {OP_WR,  3'd4, 64'h5, 64'h0, 64'h0},                    // R9
      {OP_RD,  3'd4, 64'h0, 64'h0, 64'h1},                    // R9
      {OP_BR,  3'd0, 64'h0, 64'h0, 64'h0},                    // R7
      {OP_RD,  3'd4, 64'h0, 64'h0, 64'h0},                    // R7
      {OP_EVT, 3'd0, 64'h40, 64'h0, 64'h0000_0000_0000_0040}  // R7 R5
   };

   logic        clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
   logic        req_valid = 1'b0, req_wr = 1'b0;
   logic [2:0]  req_idx = '0;
   logic [31:0] req_wdata = '0, rd_data;
   logic        cas_valid = 1'b0, cas_done;
   logic [63:0] cas_cmp = '0, cas_new = '0, cas_old, ntf_addr;
   logic [31:0] evt_in = '0, ntf_data;
   logic [7:0]  clk_src, clk_rate;
   logic        stream_en, ntf_req, ntf_ack = 1'b0;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   oen_regs_top i_oen_regs_top (
      .clk, .rst_n, .bus_rst, .req_valid, .req_wr, .req_idx, .req_wdata,
      .rd_data, .cas_valid, .cas_cmp, .cas_new, .cas_old, .cas_done,
      .evt_in, .clk_src, .clk_rate, .stream_en, .ntf_req, .ntf_ack,
      .ntf_addr, .ntf_data
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] op, input logic [2:0] idx,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] e);
      case (op)
         OP_WR:  begin req_valid = 1; req_wr = 1; req_idx = idx; req_wdata = a[31:0]; end
         OP_RD:  begin req_valid = 1; req_wr = 0; req_idx = idx; end
         OP_CAS: begin cas_valid = 1; cas_cmp = a; cas_new = b; end
         OP_EVT: evt_in = a[31:0];
         OP_BR:  bus_rst = 1;
         OP_ACK: ntf_ack = 1;
         default: ;
      endcase
      #1;
      if (op == OP_RD) chk(rd_data == e[31:0], "R1/R2/R3/R8/R9 read", 64'(rd_data), e);
      if (op == OP_ADR) chk(ntf_addr == e, "R5 address", ntf_addr, e);
      @(negedge clk);
      req_valid = 0; req_wr = 0; cas_valid = 0; evt_in = '0; bus_rst = 0; ntf_ack = 0;
      #1;
      if (op == OP_CAS) chk(cas_done && cas_old == e, "R3 old value", cas_old, e);
      if (op == OP_EVT) chk({ntf_req, ntf_data} == e[32:0], "R4/R5 event",
                            64'({ntf_req, ntf_data}), e);
      if (op == OP_ACK) chk(ntf_req == e[0], "R6 ack", 64'(ntf_req), e);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset outputs
      chk(!ntf_req && !stream_en, "R1 outputs", 64'({ntf_req, stream_en}), 64'h0);
      chk(clk_src == 8'h0C && clk_rate == 8'h02, "R1 clock sel",
          64'({clk_rate, clk_src}), 64'h020C);

      for (int i = 0; i < NV; i++)
         step(VEC[i][197:195], VEC[i][194:192], VEC[i][191:128], VEC[i][127:64], VEC[i][63:0]);

      // R8 outputs from the table write
      chk(clk_src == 8'h07 && clk_rate == 8'h04, "R8 outputs",
          64'({clk_rate, clk_src}), 64'h0407);

      // R6: request held without ack, replaced data while pending
      step(OP_CAS, 0, NOWN, OWN2, NOWN);
      step(OP_EVT, 0, 64'h1, 0, 64'h1_0000_0001);
      repeat (4) @(negedge clk);
      chk(ntf_req, "R6 hold", 64'(ntf_req), 64'h1);
      step(OP_EVT, 0, 64'h2, 0, 64'h1_0000_0002);
      step(OP_ADR, 0, 0, 0, OWN2);
      // R7: bus reset drops request and owner
      step(OP_BR, 0, 0, 0, 0);
      chk(!ntf_req, "R7 drop req", 64'(ntf_req), 64'h0);
      step(OP_RD, 3'd0, 0, 0, 64'hFFFF_0000);

      // R7: bus reset wins over a matching swap in the same cycle
      bus_rst = 1;
      step(OP_CAS, 0, NOWN, OWN1, NOWN);
      step(OP_RD, 3'd0, 0, 0, 64'hFFFF_0000);
      step(OP_RD, 3'd1, 0, 0, 64'h0);

      // R9: zero write stops the streams
      step(OP_WR, 3'd4, 64'h1, 0, 0);
      chk(stream_en, "R9 start", 64'(stream_en), 64'h1);
      step(OP_WR, 3'd4, 64'h0, 0, 0);
      chk(!stream_en, "R9 stop", 64'(stream_en), 64'h0);
      step(OP_RD, 3'd4, 0, 0, 64'h0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule